// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog Timer

This block is a watchdog timer with a 16-bit register port and a single bus clock. A counter advances once per divided clock tick while the timer is enabled. If software does not restart the counter before it reaches a programmed 32-bit limit, the block raises a one-cycle reset request. It can also set an interrupt flag.

Software restarts the counter by writing a two-word service key. If the second word is wrong, a reset request follows at once. In window mode, a correct service that arrives while the counter is still below the window value is also treated as a fault. Configuration registers are writable only during a short interval that opens after a two-word unlock key. The control register takes a single write per interval. Clearing the allow-update bit seals all configuration registers for good once the interval closes.

A saturating counter records how many reset requests the watchdog has raised.

Top module: `keyed_wdt`

## Requirements
- R1: Registers at addresses 0 (control), 2/3 (limit high/low), 4/5 (window high/low) and 6 (divider, bits 2:0) accept writes only during the OPEN_CYCLES (default 256) cycles that follow a valid unlock. Writes before an unlock, or after the interval has closed, leave them unchanged.
- R2: An unlock is two consecutive bus writes to address 9: 0xC520, then 0xD928. Any other write in between, or any other second word, leaves the registers locked.
- R3: Within one unlock interval, only the first write to the control register takes effect. The control bits are: bit0 run, bit1 clock select (stored only), bit2 interrupt enable, bit3 window mode, bit4 allow-update, bits 7:5 stored only.
- R4: If allow-update is 0 when an unlock interval closes, no later unlock opens the configuration registers again until rstN.
- R5: Two consecutive writes to address 10, 0xA602 then 0xB480, clear the counter to zero at the edge of the second write (outside a window fault).
- R6: If 0xA602 at address 10 is followed there by any other word, rstReq is high in the cycle right after that write's edge.
- R7: In window mode, a correct service arriving while the counter is below the 32-bit window value raises rstReq in the same way as R6 and clears the counter.
- R8: While running with divider code p, the counter (read at addresses 7/8) advances once every p+1 cycles. On the cycle after it equals the limit, rstReq is high for exactly one cycle and the counter restarts from zero.
- R9: A limit expiry with interrupt enable set raises the interrupt flag (address 1, bit0) and irq. Writing 1 to that bit clears it.
- R10: Every watchdog reset request increments the reset count at address 11, saturating at all ones of RC_W bits. Writing 0xFFFF clears it, and any other value is ignored.
- R11: After rstN: control reads 0x0010, the limit equals TO_RST, window, divider, counter, flag and reset count read 0, and rstReq and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low power-on reset |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | 4 | Register address for read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data of the addressed register |
| rstReq | output | 1 | One-cycle reset request |
| irq | output | 1 | Interrupt, flag and enable both set |

## Verification
The hardest states to reach are the permanent lock and a window fault that is timed against the counter. The permanent lock needs an unlock, a control write that clears allow-update, and a wait past the interval before a second unlock can show that writes have no effect. The window case sends the service key just after enabling, while the counter is still below the window, and then a second service once the counter has passed it. Every reset request is predicted as an exact cycle number and queued, so that an early or missing pulse is reported as well as a late one. Saturation of the reset count is reached in a short run by building the bench with a narrow count.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_STAT   = 4'd1;
  localparam logic [3:0] A_TO_HI  = 4'd2;
  localparam logic [3:0] A_TO_LO  = 4'd3;
  localparam logic [3:0] A_WIN_HI = 4'd4;
  localparam logic [3:0] A_WIN_LO = 4'd5;
  localparam logic [3:0] A_DIV    = 4'd6;
  localparam logic [3:0] A_CNT_HI = 4'd7;
  localparam logic [3:0] A_CNT_LO = 4'd8;
  localparam logic [3:0] A_UNLOCK = 4'd9;
  localparam logic [3:0] A_SVC    = 4'd10;
  localparam logic [3:0] A_RCNT   = 4'd11;

  localparam logic [15:0] KEY_OPEN1 = 16'hC520;
  localparam logic [15:0] KEY_OPEN2 = 16'hD928;
  localparam logic [15:0] KEY_SVC1  = 16'hA602;
  localparam logic [15:0] KEY_SVC2  = 16'hB480;
  localparam logic [15:0] RCNT_CLR  = 16'hFFFF;

  localparam logic [7:0] CTRL_RST = 8'h10;

  typedef struct packed {
    logic ctrlWr;
    logic toHiWr;
    logic toLoWr;
    logic winHiWr;
    logic winLoWr;
    logic divWr;
    logic flagClr;
    logic rcClr;
    logic service;
    logic fault;
  } wdt_strobe_t;
endpackage

// File: rtl/keyed_wdt_ctrl.sv
module keyed_wdt_ctrl
  import keyed_wdt_pkg::*;
#(
  parameter int OPEN_CYCLES = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  addr,
  input  logic [15:0] wrData,
  input  logic        allowUpdate,
  input  logic        windowEn,
  input  logic        early,
  output wdt_strobe_t strb,
  output logic        cfgOpen
);
  localparam int OW = $clog2(OPEN_CYCLES + 1);

  logic [OW-1:0] openCnt;
  logic ctrlDone, permLock, openArmed, svcArmed;
  logic isOpen, isSvc, openGo, svcSecond, svcGood;

  assign isOpen    = wrEn && (addr == A_UNLOCK);
  assign isSvc     = wrEn && (addr == A_SVC);
  assign openGo    = isOpen && openArmed && (wrData == KEY_OPEN2) && !permLock;
  assign svcSecond = isSvc && svcArmed;
  assign svcGood   = svcSecond && (wrData == KEY_SVC2);
  assign cfgOpen   = (openCnt != '0) && !permLock;

  always_comb begin
    strb         = '0;
    strb.ctrlWr  = wrEn && cfgOpen && !ctrlDone && (addr == A_CTRL);
    strb.toHiWr  = wrEn && cfgOpen && (addr == A_TO_HI);
    strb.toLoWr  = wrEn && cfgOpen && (addr == A_TO_LO);
    strb.winHiWr = wrEn && cfgOpen && (addr == A_WIN_HI);
    strb.winLoWr = wrEn && cfgOpen && (addr == A_WIN_LO);
    strb.divWr   = wrEn && cfgOpen && (addr == A_DIV);
    strb.flagClr = wrEn && (addr == A_STAT) && wrData[0];
    strb.rcClr   = wrEn && (addr == A_RCNT) && (wrData == RCNT_CLR);
    strb.service = svcGood && !(windowEn && early);
    strb.fault   = (svcSecond && !svcGood) || (svcGood && windowEn && early);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openCnt   <= '0;
      ctrlDone  <= 1'b0;
      permLock  <= 1'b0;
      openArmed <= 1'b0;
      svcArmed  <= 1'b0;
    end else begin
      if (wrEn) begin
        openArmed <= isOpen && (wrData == KEY_OPEN1);
        svcArmed  <= isSvc && (wrData == KEY_SVC1);
      end
      if (openGo) begin
        openCnt  <= OW'(OPEN_CYCLES);
        ctrlDone <= 1'b0;
      end else begin
        if (openCnt != '0) openCnt <= openCnt - OW'(1);
        if (strb.ctrlWr) ctrlDone <= 1'b1;
        if ((openCnt == OW'(1)) && !allowUpdate) permLock <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/keyed_wdt_dp.sv
module keyed_wdt_dp
  import keyed_wdt_pkg::*;
#(
  parameter int          RC_W   = 16,
  parameter logic [31:0] TO_RST = 32'h0000_4000
) (
  input  logic            clk,
  input  logic            rstN,
  input  wdt_strobe_t     strb,
  input  logic [3:0]      addr,
  input  logic [15:0]     wrData,
  output logic [15:0]     rdData,
  output logic            allowUpdate,
  output logic            windowEn,
  output logic            early,
  output logic            rstReq,
  output logic            irq,
  output logic [31:0]     cntVal,
  output logic [31:0]     timeoutVal,
  output logic [7:0]      ctrlVal,
  output logic [RC_W-1:0] rstCntVal
);
  logic [31:0] winVal;
  logic [2:0]  divCode, divCnt;
  logic        intFlag, running, tick, hit, restart;

  assign running     = ctrlVal[0];
  assign windowEn    = ctrlVal[3];
  assign allowUpdate = ctrlVal[4];
  assign tick        = running && (divCnt == divCode);
  assign hit         = running && (cntVal >= timeoutVal);
  assign early       = cntVal < winVal;
  assign restart     = hit || strb.service || strb.fault;
  assign irq         = intFlag && ctrlVal[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlVal    <= CTRL_RST;
      timeoutVal <= TO_RST;
      winVal     <= '0;
      divCode    <= '0;
      divCnt     <= '0;
      cntVal     <= '0;
      intFlag    <= 1'b0;
      rstReq     <= 1'b0;
      rstCntVal  <= '0;
    end else begin
      if (strb.ctrlWr)  ctrlVal            <= wrData[7:0];
      if (strb.toHiWr)  timeoutVal[31:16]  <= wrData;
      if (strb.toLoWr)  timeoutVal[15:0]   <= wrData;
      if (strb.winHiWr) winVal[31:16]      <= wrData;
      if (strb.winLoWr) winVal[15:0]       <= wrData;
      if (strb.divWr)   divCode            <= wrData[2:0];

      if (!running || tick || restart) divCnt <= '0;
      else                             divCnt <= divCnt + 3'd1;

      if (restart)   cntVal <= '0;
      else if (tick) cntVal <= cntVal + 32'd1;

      rstReq <= hit || strb.fault;

      if (hit && ctrlVal[2]) intFlag <= 1'b1;
      else if (strb.flagClr) intFlag <= 1'b0;

      if (strb.rcClr) rstCntVal <= '0;
      else if ((hit || strb.fault) && (rstCntVal != '1)) rstCntVal <= rstCntVal + 1'b1;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:   rdData = {8'h00, ctrlVal};
      A_STAT:   rdData = {15'h0000, intFlag};
      A_TO_HI:  rdData = timeoutVal[31:16];
      A_TO_LO:  rdData = timeoutVal[15:0];
      A_WIN_HI: rdData = winVal[31:16];
      A_WIN_LO: rdData = winVal[15:0];
      A_DIV:    rdData = {13'h0000, divCode};
      A_CNT_HI: rdData = cntVal[31:16];
      A_CNT_LO: rdData = cntVal[15:0];
      A_RCNT:   rdData = 16'(rstCntVal);
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int          OPEN_CYCLES = 256,
  parameter int          RC_W        = 16,
  parameter logic [31:0] TO_RST      = 32'h0000_4000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        rstReq,
  output logic        irq
);
  wdt_strobe_t     strb;
  logic            cfgOpen, allowUpdate, windowEn, early;
  logic [31:0]     cntVal, timeoutVal;
  logic [7:0]      ctrlVal;
  logic [RC_W-1:0] rstCntVal;

  keyed_wdt_ctrl #(.OPEN_CYCLES(OPEN_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .allowUpdate(allowUpdate), .windowEn(windowEn), .early(early),
    .strb(strb), .cfgOpen(cfgOpen)
  );

  keyed_wdt_dp #(.RC_W(RC_W), .TO_RST(TO_RST)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .allowUpdate(allowUpdate), .windowEn(windowEn),
    .early(early), .rstReq(rstReq), .irq(irq), .cntVal(cntVal),
    .timeoutVal(timeoutVal), .ctrlVal(ctrlVal), .rstCntVal(rstCntVal)
  );
endmodule

// File: rtl/keyed_wdt_check.sv
module keyed_wdt_check
  import keyed_wdt_pkg::*;
#(
  parameter int RC_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input wdt_strobe_t     strb,
  input logic            cfgOpen,
  input logic            rstReq,
  input logic [31:0]     cntVal,
  input logic [31:0]     timeoutVal,
  input logic [7:0]      ctrlVal,
  input logic [RC_W-1:0] rstCntVal
);
  // R1: closed interval keeps configuration unchanged
  p_closed_stable_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOpen |=> ($stable(timeoutVal) && $stable(ctrlVal)));

  // R5: a good service leaves the counter at zero
  p_service_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.service |=> (cntVal == 32'd0));

  // R6: a key fault yields a reset request next cycle
  p_fault_request_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.fault |=> rstReq);

  // R8: reset request lasts one cycle
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  // R10: reset count holds at saturation
  p_count_saturates_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((rstCntVal == '1) && !strb.rcClr) |=> (rstCntVal == '1));
endmodule

bind keyed_wdt keyed_wdt_check #(.RC_W(RC_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .cfgOpen(cfgOpen), .rstReq(rstReq),
  .cntVal(cntVal), .timeoutVal(timeoutVal), .ctrlVal(ctrlVal),
  .rstCntVal(rstCntVal)
);

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
  localparam int CLK_PERIOD = 10;
  localparam int RCW = 4;
  localparam logic [31:0] TO_DEF = 32'h0000_4000;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wrData = '0, rdData;
  logic rstReq, irq;

  int tests = 0, fails = 0, cyc = 0;
  int expQ[$];
  bit finished = 0;

  keyed_wdt #(.OPEN_CYCLES(256), .RC_W(RCW), .TO_RST(TO_DEF)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rstReq(rstReq), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: compares every reset request against the queued prediction
  always @(negedge clk) begin
    #2;
    if (rstN && rstReq) begin
      if (expQ.size() == 0) check(1'b0, "R8 unexpected rstReq", cyc, -1);
      else begin
        int e;
        e = expQ.pop_front();
        check(cyc == e, "R8 rstReq cycle", cyc, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d, output int edgeN);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    edgeN = cyc;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expQ.delete();
  endtask

  task automatic unlock();
    int t;
    wr(4'd9, 16'hC520, t);
    wr(4'd9, 16'hD928, t);
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int e, s, t;
    doReset();

    // R11 reset state
    rd(4'd0, v); check(v == 16'h0010, "R11 ctrl", v, 16'h0010);
    rd(4'd3, v); check(v == TO_DEF[15:0], "R11 limit low", v, TO_DEF[15:0]);
    rd(4'd8, v); check(v == 0, "R11 counter", v, 0);
    rd(4'd11, v); check(v == 0, "R11 reset count", v, 0);
    check(!rstReq && !irq, "R11 outputs", {rstReq, irq}, 0);

    // R1 write without unlock ignored
    wr(4'd3, 16'h0055, t);
    rd(4'd3, v); check(v == TO_DEF[15:0], "R1 locked write", v, TO_DEF[15:0]);

    // R2 broken unlock pair
    wr(4'd9, 16'hC520, t); wr(4'd9, 16'h1234, t); wr(4'd9, 16'hD928, t);
    wr(4'd3, 16'h0099, t);
    rd(4'd3, v); check(v == TO_DEF[15:0], "R2 bad key", v, TO_DEF[15:0]);

    // R1/R3/R8/R9/R10 timeout with interrupt, divide by 1
    unlock();
    wr(4'd2, 16'h0000, t); wr(4'd3, 16'd20, t);
    rd(4'd3, v); check(v == 16'd20, "R1 open write", v, 20);
    wr(4'd0, 16'h0015, e);
    expQ.push_back(e + 21);
    wr(4'd0, 16'h0010, t);
    rd(4'd0, v); check(v == 16'h0015, "R3 second ctrl write", v, 16'h0015);
    waitUntil(e + 23);
    rd(4'd1, v); check(v[0] == 1'b1, "R9 flag set", v, 1);
    check(irq == 1'b1, "R9 irq", irq, 1);
    wr(4'd1, 16'h0001, t);
    rd(4'd1, v); check(v[0] == 1'b0, "R9 flag clear", v, 0);
    check(irq == 1'b0, "R9 irq clear", irq, 0);
    rd(4'd11, v); check(v == 1, "R10 count one", v, 1);
    doReset();

    // R8 divider code 2 -> advance every 3 cycles
    unlock();
    wr(4'd2, 16'h0000, t); wr(4'd3, 16'd5, t); wr(4'd6, 16'd2, t);
    wr(4'd0, 16'h0011, e);
    expQ.push_back(e + 16);
    for (int k = 1; k <= 7; k++) begin
      rd(4'd8, v);
      check(v == (cyc - e) / 3, "R8 divided count", v, (cyc - e) / 3);
    end
    waitUntil(e + 20);
    rd(4'd8, v); check(v == (cyc - (e + 16)) / 3, "R8 restart", v, (cyc - (e + 16)) / 3);
    doReset();

    // R5 service clears counter
    unlock();
    wr(4'd2, 16'h0000, t); wr(4'd3, 16'd30, t);
    wr(4'd0, 16'h0011, e);
    waitUntil(e + 15);
    wr(4'd10, 16'hA602, t); wr(4'd10, 16'hB480, s);
    expQ.push_back(s + 31);
    rd(4'd8, v); check(v == cyc - s, "R5 counter after service", v, cyc - s);
    rd(4'd8, v); check(v == cyc - s, "R5 counter runs on", v, cyc - s);
    waitUntil(s + 40);
    doReset();

    // R6/R10 bad second service word, saturation, clear
    for (int i = 0; i < 20; i++) begin
      wr(4'd10, 16'hA602, t); wr(4'd10, 16'h0000, s);
      expQ.push_back(s);
    end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R6 all faults seen", expQ.size(), 0);
    rd(4'd11, v); check(v == 15, "R10 saturate", v, 15);
    wr(4'd11, 16'h1234, t);
    rd(4'd11, v); check(v == 15, "R10 wrong clear word", v, 15);
    wr(4'd11, 16'hFFFF, t);
    rd(4'd11, v); check(v == 0, "R10 clear", v, 0);

    // R7 window mode
    unlock();
    wr(4'd2, 16'h0000, t); wr(4'd3, 16'd50, t);
    wr(4'd4, 16'h0000, t); wr(4'd5, 16'd10, t);
    wr(4'd0, 16'h0019, e);
    wr(4'd10, 16'hA602, t); wr(4'd10, 16'hB480, s);
    expQ.push_back(s);
    waitUntil(s + 20);
    wr(4'd10, 16'hA602, t); wr(4'd10, 16'hB480, e);
    expQ.push_back(e + 51);
    rd(4'd8, v); check(v == cyc - e, "R7 late service accepted", v, cyc - e);
    waitUntil(e + 53);
    check(expQ.size() == 0, "R7 events seen", expQ.size(), 0);
    rd(4'd11, v); check(v == 2, "R7 reset count", v, 2);
    doReset();

    // R1 interval expiry
    unlock();
    repeat (300) @(negedge clk);
    wr(4'd3, 16'h0077, t);
    rd(4'd3, v); check(v == TO_DEF[15:0], "R1 expired interval", v, TO_DEF[15:0]);

    // R4 permanent lock
    unlock();
    wr(4'd3, 16'h0033, t);
    wr(4'd0, 16'h0000, t);
    repeat (300) @(negedge clk);
    unlock();
    wr(4'd3, 16'h0044, t);
    rd(4'd3, v); check(v == 16'h0033, "R4 sealed limit", v, 16'h0033);
    rd(4'd0, v); check(v == 16'h0000, "R4 sealed ctrl", v, 0);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8 queue drained", expQ.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule